// File: doc/BRIEF.md
# Unified Translation Buffer with Lockdown Region

This block caches virtual-to-physical page translations for both instruction and data fetches in one shared store. The store has two parts. The main part is set-associative: the low bits of the virtual page number pick a set, and each set holds several ways. The lockdown part is a small fully-associative array. It holds pinned translations that a bulk flush must not disturb.

A lookup compares the requested virtual page against both parts in the same cycle. The physical page and a hit flag appear on the outputs after the next clock edge. A fill port writes new translations. A flag on the fill chooses the lockdown part, where the entry takes the lowest free slot; otherwise the entry goes to the main part, with round-robin replacement within its set.

A write-only maintenance port takes a 3-bit operation field and a 4-bit target field. Six combinations are defined: flush everything, or flush one virtual page, each aimed at the instruction side, the data side or both. All six act on the one shared store. Any other combination does nothing.

Top module: `tlb_unified`

## Requirements
- R1: After reset every entry is invalid, so a lookup returns `lkHit` = 0 and `lkPpn` = 0.
- R2: A lookup presented with `lkValid` = 1 before clock edge k returns its result after edge k. On a match with a valid entry it returns `lkHit` = 1 and that entry's physical page. Otherwise it returns `lkHit` = 0 and `lkPpn` = 0. When `lkValid` = 0, the result after the edge is `lkHit` = 0.
- R3: A fill with `fillLock` = 0 writes the main part. The set index is the low log2(SETS) bits of `fillVpn`. The ways of each set are replaced round-robin, starting at way 0. With 2 ways, a third fill into one set evicts the first.
- R4: A fill with `fillLock` = 1 writes the lowest-numbered free lockdown slot. When all LOCK_N slots are valid, the fill is dropped. A slot freed by a single-page flush is used again.
- R5: If a virtual page hits in both parts, the lookup returns the lockdown entry's physical page.
- R6: The flush-all operation (`mntOp2` = 0) invalidates every main-part entry and leaves every lockdown entry valid.
- R7: The flush-page operation (`mntOp2` = 1) invalidates every entry in either part whose virtual page equals `mntVa`, including lockdown entries.
- R8: The target field selects the instruction side (`mntCrm` = 5), the data side (6) or both (7). Each of these values has the same effect on the shared store.
- R9: Any other maintenance combination (`mntCrm` outside 5 to 7, or `mntOp2` above 1) changes no entry.
- R10: If a defined maintenance operation arrives in the same cycle as a fill, the maintenance operation is applied and the fill is dropped. An undefined combination does not block a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVpn | input | VPN_W | Virtual page to translate |
| lkHit | output | 1 | Registered hit flag |
| lkPpn | output | PPN_W | Registered physical page, 0 on miss |
| fillValid | input | 1 | Fill strobe |
| fillLock | input | 1 | Fill targets the lockdown part |
| fillVpn | input | VPN_W | Virtual page of the fill |
| fillPpn | input | PPN_W | Physical page of the fill |
| mntValid | input | 1 | Maintenance write strobe |
| mntOp2 | input | 3 | Operation field: 0 flush all, 1 flush page |
| mntCrm | input | 4 | Target field: 5 instruction, 6 data, 7 both |
| mntVa | input | VPN_W | Virtual page for flush-page |

## Verification
The assertions assume that no virtual page is present twice in the main part. The bench therefore never fills a page that is still resident. The lockdown-preservation check assumes that a flush-all never coincides with a lockdown write; the control guarantees this, because a defined maintenance operation suppresses the fill. All stimulus is driven on the falling edge and held for exactly one cycle, so each fill, flush and lookup covers one rising edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic invAll;
    logic invOne;
    logic wrMain;
    logic wrLock;
  } tlbStrobe_t;

  localparam logic [3:0] TGT_INSN = 4'd5;
  localparam logic [3:0] TGT_DATA = 4'd6;
  localparam logic [3:0] TGT_BOTH = 4'd7;
  localparam logic [2:0] OP_ALL   = 3'd0;
  localparam logic [2:0] OP_ONE   = 3'd1;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int WAYS   = 2,
  parameter int LOCK_N = 4,
  parameter int SET_W  = $clog2(SETS),
  parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  parameter int SLOT_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mntValid,
  input  logic [2:0]        mntOp2,
  input  logic [3:0]        mntCrm,
  input  logic              fillValid,
  input  logic              fillLock,
  input  logic [SET_W-1:0]  fillSet,
  input  logic [LOCK_N-1:0] lockValid,
  output tlbStrobe_t        strobe,
  output logic [WAY_W-1:0]  wrWay,
  output logic [SLOT_W-1:0] wrSlot
);
  logic [WAY_W-1:0] rrPtr [SETS];
  logic tgtOk, opOk, isMnt, lockFree;
  logic [SLOT_W-1:0] freeSlot;

  assign tgtOk = (mntCrm == TGT_INSN) || (mntCrm == TGT_DATA) || (mntCrm == TGT_BOTH);
  assign opOk  = (mntOp2 == OP_ALL) || (mntOp2 == OP_ONE);
  assign isMnt = mntValid && tgtOk && opOk;

  always_comb begin
    lockFree = 1'b0;
    freeSlot = '0;
    for (int i = LOCK_N - 1; i >= 0; i--) begin
      if (!lockValid[i]) begin
        lockFree = 1'b1;
        freeSlot = SLOT_W'(i);
      end
    end
  end

  assign strobe.invAll = isMnt && (mntOp2 == OP_ALL);
  assign strobe.invOne = isMnt && (mntOp2 == OP_ONE);
  assign strobe.wrMain = fillValid && !fillLock && !isMnt;
  assign strobe.wrLock = fillValid && fillLock && !isMnt && lockFree;
  assign wrWay  = rrPtr[fillSet];
  assign wrSlot = freeSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else if (strobe.wrMain) begin
      rrPtr[fillSet] <= (rrPtr[fillSet] == WAY_W'(WAYS - 1)) ? '0 : rrPtr[fillSet] + 1'b1;
    end
  end

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.invAll, strobe.invOne, strobe.wrMain, strobe.wrLock}));

  assert_lock_slot_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLock |-> !lockValid[wrSlot]);

  assert_undefined_no_effect_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mntValid && !(tgtOk && opOk)) |-> !(strobe.invAll || strobe.invOne));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int SETS   = 8,
  parameter int WAYS   = 2,
  parameter int LOCK_N = 4,
  parameter int SET_W  = $clog2(SETS),
  parameter int TAG_W  = VPN_W - SET_W,
  parameter int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  parameter int SLOT_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [VPN_W-1:0]  mntVa,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic [LOCK_N-1:0] lockValid,
  output logic              lkHit,
  output logic [PPN_W-1:0]  lkPpn
);
  logic [WAYS-1:0]  mainV   [SETS];
  logic [TAG_W-1:0] mainTag [SETS][WAYS];
  logic [PPN_W-1:0] mainPpn [SETS][WAYS];
  logic [LOCK_N-1:0] lockV;
  logic [VPN_W-1:0] lockVpn [LOCK_N];
  logic [PPN_W-1:0] lockPpn [LOCK_N];

  logic [SET_W-1:0] fSet, mSet, lSet;
  logic [TAG_W-1:0] fTag, mTag, lTag;
  logic mHit, lHit;
  logic [PPN_W-1:0] mPpn, lPpn;
  logic [SETS*WAYS-1:0] mainVflat;

  assign fSet = fillVpn[SET_W-1:0];
  assign fTag = fillVpn[VPN_W-1:SET_W];
  assign mSet = mntVa[SET_W-1:0];
  assign mTag = mntVa[VPN_W-1:SET_W];
  assign lSet = lkVpn[SET_W-1:0];
  assign lTag = lkVpn[VPN_W-1:SET_W];
  assign lockValid = lockV;

  for (genvar g = 0; g < SETS; g++) begin : gFlat
    assign mainVflat[g*WAYS +: WAYS] = mainV[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) mainV[s] <= '0;
      lockV <= '0;
    end else begin
      if (strobe.invAll) begin
        for (int s = 0; s < SETS; s++) mainV[s] <= '0;
      end
      if (strobe.invOne) begin
        for (int w = 0; w < WAYS; w++)
          if (mainV[mSet][w] && mainTag[mSet][w] == mTag) mainV[mSet][w] <= 1'b0;
        for (int l = 0; l < LOCK_N; l++)
          if (lockV[l] && lockVpn[l] == mntVa) lockV[l] <= 1'b0;
      end
      if (strobe.wrMain) mainV[fSet][wrWay] <= 1'b1;
      if (strobe.wrLock) lockV[wrSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrMain) begin
      mainTag[fSet][wrWay] <= fTag;
      mainPpn[fSet][wrWay] <= fillPpn;
    end
    if (strobe.wrLock) begin
      lockVpn[wrSlot] <= fillVpn;
      lockPpn[wrSlot] <= fillPpn;
    end
  end

  always_comb begin
    mHit = 1'b0;
    mPpn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (mainV[lSet][w] && mainTag[lSet][w] == lTag) begin
        mHit = 1'b1;
        mPpn = mainPpn[lSet][w];
      end
    end
    lHit = 1'b0;
    lPpn = '0;
    for (int l = 0; l < LOCK_N; l++) begin
      if (lockV[l] && lockVpn[l] == lkVpn) begin
        lHit = 1'b1;
        lPpn = lockPpn[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHit <= 1'b0;
      lkPpn <= '0;
    end else begin
      lkHit <= lkValid && (mHit || lHit);
      lkPpn <= !lkValid ? '0 : lHit ? lPpn : mHit ? mPpn : '0;
    end
  end

  assert_flush_clears_main_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.invAll |=> (mainVflat == '0));

  assert_flush_keeps_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.invAll |=> (lockV == $past(lockV)));

  assert_miss_ppn_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPpn == '0));

  assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !lkHit);
endmodule

// File: rtl/tlb_unified.sv
module tlb_unified
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int SETS   = 8,
  parameter int WAYS   = 2,
  parameter int LOCK_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VPN_W-1:0] lkVpn,
  output logic             lkHit,
  output logic [PPN_W-1:0] lkPpn,
  input  logic             fillValid,
  input  logic             fillLock,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             mntValid,
  input  logic [2:0]       mntOp2,
  input  logic [3:0]       mntCrm,
  input  logic [VPN_W-1:0] mntVa
);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SLOT_W = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;

  tlbStrobe_t        strobe;
  logic [WAY_W-1:0]  wrWay;
  logic [SLOT_W-1:0] wrSlot;
  logic [LOCK_N-1:0] lockValid;

  tlb_ctrl #(
    .SETS(SETS), .WAYS(WAYS), .LOCK_N(LOCK_N),
    .SET_W(SET_W), .WAY_W(WAY_W), .SLOT_W(SLOT_W)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .mntValid(mntValid), .mntOp2(mntOp2), .mntCrm(mntCrm),
    .fillValid(fillValid), .fillLock(fillLock), .fillSet(fillVpn[SET_W-1:0]),
    .lockValid(lockValid),
    .strobe(strobe), .wrWay(wrWay), .wrSlot(wrSlot)
  );

  tlb_datapath #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(SETS), .WAYS(WAYS), .LOCK_N(LOCK_N),
    .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W), .SLOT_W(SLOT_W)
  ) dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrWay(wrWay), .wrSlot(wrSlot),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .mntVa(mntVa),
    .lkValid(lkValid), .lkVpn(lkVpn),
    .lockValid(lockValid), .lkHit(lkHit), .lkPpn(lkPpn)
  );
endmodule

// File: tb/tlb_unified_test.sv
`timescale 1ns/1ps
module tlb_unified_test;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [VPN_W-1:0] lkVpn = '0;
  logic lkHit;
  logic [PPN_W-1:0] lkPpn;
  logic fillValid = 1'b0, fillLock = 1'b0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  logic mntValid = 1'b0;
  logic [2:0] mntOp2 = '0;
  logic [3:0] mntCrm = '0;
  logic [VPN_W-1:0] mntVa = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tlb_unified uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkHit(lkHit), .lkPpn(lkPpn),
    .fillValid(fillValid), .fillLock(fillLock), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .mntValid(mntValid), .mntOp2(mntOp2), .mntCrm(mntCrm), .mntVa(mntVa)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(logic [VPN_W-1:0] vpn, bit expHit, logic [PPN_W-1:0] expPpn, string req);
    @(negedge clk);
    lkValid = 1'b1; lkVpn = vpn;
    @(negedge clk);
    lkValid = 1'b0;
    chk({req, " hit"}, 32'(lkHit), 32'(expHit));
    chk({req, " ppn"}, 32'(lkPpn), expHit ? 32'(expPpn) : 32'h0);
  endtask

  task automatic fill(logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, bit lock);
    @(negedge clk);
    fillValid = 1'b1; fillLock = lock; fillVpn = vpn; fillPpn = ppn;
    @(negedge clk);
    fillValid = 1'b0; fillLock = 1'b0;
  endtask

  task automatic mnt(logic [2:0] op, logic [3:0] crm, logic [VPN_W-1:0] va);
    @(negedge clk);
    mntValid = 1'b1; mntOp2 = op; mntCrm = crm; mntVa = va;
    @(negedge clk);
    mntValid = 1'b0;
  endtask

  task automatic both(logic [2:0] op, logic [3:0] crm, logic [VPN_W-1:0] va,
                      logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn);
    @(negedge clk);
    mntValid = 1'b1; mntOp2 = op; mntCrm = crm; mntVa = va;
    fillValid = 1'b1; fillLock = 1'b0; fillVpn = vpn; fillPpn = ppn;
    @(negedge clk);
    mntValid = 1'b0; fillValid = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 reset hit", 32'(lkHit), 32'h0);
    chk("R1 reset ppn", 32'(lkPpn), 32'h0);
    look(20'h00011, 1'b0, '0, "R1 empty lookup");
  endtask

  task automatic testBasic();
    fill(20'h00011, 20'h00111, 1'b0);
    look(20'h00011, 1'b1, 20'h00111, "R2 R3 main hit");
    look(20'h00019, 1'b0, '0, "R2 same set other tag miss");
    @(negedge clk);
    lkVpn = 20'h00011; lkValid = 1'b0;
    @(negedge clk);
    chk("R2 idle lookup no hit", 32'(lkHit), 32'h0);
  endtask

  task automatic testRoundRobin();
    fill(20'h00102, 20'h00001, 1'b0);
    fill(20'h00202, 20'h00002, 1'b0);
    fill(20'h00302, 20'h00003, 1'b0);
    look(20'h00102, 1'b0, '0, "R3 oldest evicted");
    look(20'h00202, 1'b1, 20'h00002, "R3 second kept");
    look(20'h00302, 1'b1, 20'h00003, "R3 third kept");
  endtask

  task automatic testLockFill();
    for (int i = 0; i < 4; i++) fill(20'h0A000 + 20'(i), 20'h0C000 + 20'(i), 1'b1);
    for (int i = 0; i < 4; i++) look(20'h0A000 + 20'(i), 1'b1, 20'h0C000 + 20'(i), "R4 lock hit");
    fill(20'h0A004, 20'h0C004, 1'b1);
    look(20'h0A004, 1'b0, '0, "R4 full lockdown drops fill");
  endtask

  task automatic testPriority();
    fill(20'h0A000, 20'h00555, 1'b0);
    look(20'h0A000, 1'b1, 20'h0C000, "R5 lockdown wins");
  endtask

  task automatic testFlushAll();
    mnt(3'd0, 4'd7, '0);
    look(20'h00011, 1'b0, '0, "R6 main cleared");
    look(20'h00302, 1'b0, '0, "R6 main cleared set2");
    look(20'h0A001, 1'b1, 20'h0C001, "R6 lock kept");
    look(20'h0A000, 1'b1, 20'h0C000, "R6 lock kept slot0");
  endtask

  task automatic testFlushOne();
    mnt(3'd1, 4'd7, 20'h0A001);
    look(20'h0A001, 1'b0, '0, "R7 lock entry removed");
    look(20'h0A002, 1'b1, 20'h0C002, "R7 other lock kept");
    fill(20'h0B000, 20'h0D000, 1'b1);
    look(20'h0B000, 1'b1, 20'h0D000, "R4 freed slot reused");
    fill(20'h00044, 20'h00444, 1'b0);
    fill(20'h00045, 20'h00445, 1'b0);
    mnt(3'd1, 4'd5, 20'h00044);
    look(20'h00044, 1'b0, '0, "R7 R8 insn side page flush");
    look(20'h00045, 1'b1, 20'h00445, "R7 neighbour kept");
  endtask

  task automatic testDataSide();
    fill(20'h00055, 20'h00555, 1'b0);
    mnt(3'd0, 4'd6, '0);
    look(20'h00055, 1'b0, '0, "R8 data side flush all");
    look(20'h0A002, 1'b1, 20'h0C002, "R8 lock kept after data flush");
  endtask

  task automatic testUndefined();
    fill(20'h00066, 20'h00666, 1'b0);
    mnt(3'd0, 4'd4, '0);
    mnt(3'd2, 4'd7, 20'h00066);
    mnt(3'd1, 4'd8, 20'h00066);
    look(20'h00066, 1'b1, 20'h00666, "R9 undefined ops no effect");
  endtask

  task automatic testCollision();
    both(3'd1, 4'd7, 20'h01234, 20'h00077, 20'h00777);
    look(20'h00077, 1'b0, '0, "R10 fill dropped under maintenance");
    both(3'd3, 4'd7, 20'h00000, 20'h00088, 20'h00888);
    look(20'h00088, 1'b1, 20'h00888, "R10 undefined op lets fill through");
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testRoundRobin();
    testLockFill();
    testPriority();
    testFlushAll();
    testFlushOne();
    testDataSide();
    testUndefined();
    testCollision();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule